// File: doc/BRIEF.md
# Asynchronous Serial Transmitter with Break Generation

This block drives a single serial output line. A byte, plus an optional ninth bit, is written into a one-entry holding register through a valid/ready port. At the next bit boundary the holding register's content moves into a shift register. The shift register then sends a start bit, the data bits least significant first (the last data slot may carry parity instead), and one stop bit. The line rests high between frames.

A send-break control replaces data with break characters. A break character is a run of zeros followed by one stop bit of 1. A length select gives a short or long break. When the transmitter enable rises, one character-length of ones is sent before anything else, as a preamble.

Timing comes from an oversampling tick. Sixteen ticks make one bit time. The block reports when the holding register is empty (this is also the write-ready signal). It reports completion when the holding register is empty and nothing is being shifted out.

Back-pressure rules: a write is taken on a clock edge where `wr_valid` and `wr_ready` are both high. `wr_ready` is high exactly while the holding register is empty. It falls the cycle after a write is taken and rises again the cycle after the content moves to the shift register. A source that sees `wr_ready` low keeps `wr_valid`, `wr_data` and `wr_bit8` stable.

Top module: `serial_tx_brk`

## Requirements
- R1: After reset, `txd` is 1, `wr_ready` is 1 and `tx_done` is 1.
- R2: An 8-bit frame without parity is 10 bits, each lasting 16 `baud_tick16` pulses: a start bit 0, then data bits 0 to 7 least significant first, then a stop bit 1. With no frame in progress, the line is 1.
- R3: When `par_en` is 1, the last data slot carries parity in place of the top data bit. In 8-bit format it covers data bits 0 to 6; in 9-bit format it covers bits 0 to 7. With `par_odd` = 0, the parity bit makes the count of ones over the covered bits plus parity even; with `par_odd` = 1 it makes that count odd.
- R4: When `fmt9` is 1, a frame is 11 bits: start, data bits 0 to 7, then a ninth bit equal to the `wr_bit8` value captured with the write (or parity per R3), then stop.
- R5: If `send_brk` is 1 at a frame boundary, a break character is sent rather than held data. A break character is a run of zeros followed by a single 1. Breaks repeat for as long as `send_brk` stays 1. Held data waits and is sent after the breaks.
- R6: The zero run of a break is 10 bit times with `brk_long` = 0 and 13 with `brk_long` = 1, plus one more bit time when `fmt9` is 1.
- R7: After reset, and after every rise of `tx_en`, the first character sent is a preamble: all ones, 10 bits long (11 with `fmt9` = 1). It comes ahead of breaks and data.
- R8: `wr_ready` equals the holding register being empty. A write is taken when `wr_valid` and `wr_ready` are both 1. The holding register keeps its content until it moves into the shift register at a frame boundary; `wr_ready` rises in the cycle after that move.
- R9: `tx_done` is 1 exactly when the holding register is empty and no data, preamble or break bit is being shifted out.
- R10: While `tx_en` is 0, `txd` is 1 from the next cycle on. The frame in progress is dropped and the bit-timing phase restarts. A holding register write is still taken, and its content is kept until the transmitter is enabled again.
- R11: A new character begins on the bit boundary that ends the previous stop bit, with no idle bit time between them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| baud_tick16 | input | 1 | One-cycle pulse at sixteen times the bit rate |
| tx_en | input | 1 | Transmitter enable |
| send_brk | input | 1 | Send break characters continuously while 1 |
| brk_long | input | 1 | Break length select: 0 short, 1 long |
| fmt9 | input | 1 | 1 selects nine data bits per frame |
| par_en | input | 1 | Parity enable |
| par_odd | input | 1 | Parity sense: 0 even, 1 odd |
| wr_valid | input | 1 | Holding register write request |
| wr_ready | output | 1 | Holding register empty; write accepted when both are high |
| wr_data | input | 8 | Low data byte to transmit |
| wr_bit8 | input | 1 | Ninth data bit, used in 9-bit format |
| txd | output | 1 | Serial output line, idle high |
| tx_done | output | 1 | Holding register empty and nothing being shifted out |

## Verification
A behavioural reference model tracks the expected line level, the ready state and the completion state, and every cycle's outputs are compared against it. The byte patterns cover alternating bits, all zeros and odd and even bit counts, sent in both 8-bit and 9-bit formats, with parity off, even and odd. These patterns show whether the bit order, the ninth-bit source and the parity sense are right.

Breaks are run short and long in both formats, with a byte already waiting. This shows whether the break length is right and whether breaks take priority over data. Back-to-back zero bytes show any gap between frames as an extra falling-edge spacing. Dropping the enable mid-frame, writing a byte while disabled, and re-enabling shows whether the preamble comes first and whether the held byte survives. A slower tick pattern shows whether the bit time follows the tick and not the clock.

// File: rtl/serial_tx_pkg.sv
package serial_tx_pkg;

  typedef enum logic [1:0] {
    FK_DATA  = 2'd0,
    FK_IDLE  = 2'd1,
    FK_BREAK = 2'd2
  } frame_kind_e;

  function automatic logic parity_of(input logic [7:0] bits, input logic [7:0] mask,
                                     input logic odd);
    parity_of = (^(bits & mask)) ^ odd;
  endfunction

endpackage

// File: rtl/tx_baud_strobe.sv
module tx_baud_strobe #(
  parameter int OVS = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic tick,
  output logic bit_stb
);
  localparam int PH_W = $clog2(OVS);
  localparam logic [PH_W-1:0] PH_LAST = PH_W'(OVS - 1);

  logic [PH_W-1:0] phase;

  always_ff @(posedge clk) begin
    if (!rst_n || !en) begin
      phase <= '0;
    end else if (tick) begin
      phase <= (phase == PH_LAST) ? '0 : phase + 1'b1;
    end
  end

  assign bit_stb = en && tick && (phase == PH_LAST);

  AST_PHASE_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (phase == '0)); // R10

  AST_PHASE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !tick) |=> $stable(phase)); // R2

endmodule

// File: rtl/tx_hold_reg.sv
module tx_hold_reg #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_data,
  input  logic              in_bit8,
  input  logic              take,
  output logic              full,
  output logic [DATA_W-1:0] held_data,
  output logic              held_bit8
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      full      <= 1'b0;
      held_data <= '0;
      held_bit8 <= 1'b0;
    end else begin
      if (take) begin
        full <= 1'b0;
      end else if (in_valid && !full) begin
        full      <= 1'b1;
        held_data <= in_data;
        held_bit8 <= in_bit8;
      end
    end
  end

  assign in_ready = !full;

  AST_TAKE_NEEDS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    take |-> full); // R8

  AST_HOLD_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    (full && !take) |=> (full && $stable(held_data) && $stable(held_bit8))); // R8

  AST_TAKE_FREES: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> in_ready); // R8

endmodule

// File: rtl/tx_frame_build.sv
module tx_frame_build
  import serial_tx_pkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int FRAME_W = 16,
  parameter int CNT_W   = 5,
  parameter int BRK_SHORT = 10,
  parameter int BRK_LONG  = 13
) (
  input  frame_kind_e        kind,
  input  logic               fmt9,
  input  logic               par_en,
  input  logic               par_odd,
  input  logic               brk_long,
  input  logic [DATA_W-1:0]  data,
  input  logic               bit8,
  output logic [FRAME_W-1:0] vec,
  output logic [CNT_W-1:0]   len
);
  localparam logic [CNT_W-1:0] LEN_STD   = CNT_W'(DATA_W + 2);
  localparam logic [CNT_W-1:0] ZERO_SHRT = CNT_W'(BRK_SHORT);
  localparam logic [CNT_W-1:0] ZERO_LONG = CNT_W'(BRK_LONG);
  localparam logic [7:0] MASK_LOW = 8'h7F;
  localparam logic [7:0] MASK_ALL = 8'hFF;

  logic [CNT_W-1:0] zeros;
  logic [CNT_W-1:0] ext;
  logic             top_slot;

  assign ext   = fmt9 ? CNT_W'(1) : CNT_W'(0);
  assign zeros = (brk_long ? ZERO_LONG : ZERO_SHRT) + ext;

  always_comb begin
    if (fmt9) begin
      top_slot = par_en ? parity_of(8'(data), MASK_ALL, par_odd) : bit8;
    end else begin
      top_slot = par_en ? parity_of(8'(data), MASK_LOW, par_odd) : data[DATA_W-1];
    end
  end

  always_comb begin
    vec = '1;
    len = LEN_STD + ext;
    unique case (kind)
      FK_DATA: begin
        vec[0] = 1'b0;
        if (fmt9) begin
          vec[DATA_W:1]   = data;
          vec[DATA_W+1]   = top_slot;
        end else begin
          vec[DATA_W-1:1] = data[DATA_W-2:0];
          vec[DATA_W]     = top_slot;
        end
      end
      FK_BREAK: begin
        vec = {FRAME_W{1'b1}} << zeros;
        len = zeros + 1'b1;
      end
      default: begin
        vec = '1;
      end
    endcase
  end

endmodule

// File: rtl/tx_shift_out.sv
module tx_shift_out #(
  parameter int FRAME_W = 16,
  parameter int CNT_W   = 5
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               abort,
  input  logic               bit_stb,
  input  logic               load,
  input  logic [FRAME_W-1:0] vec,
  input  logic [CNT_W-1:0]   len,
  output logic               txd,
  output logic               busy,
  output logic               slot_free
);
  logic [FRAME_W-1:0] sh;
  logic [CNT_W-1:0]   cnt;

  always_ff @(posedge clk) begin
    if (!rst_n || abort) begin
      sh  <= '1;
      cnt <= '0;
    end else if (load) begin
      sh  <= vec;
      cnt <= len;
    end else if (bit_stb && busy) begin
      sh  <= {1'b1, sh[FRAME_W-1:1]};
      cnt <= cnt - 1'b1;
    end
  end

  assign busy      = (cnt != '0);
  assign slot_free = bit_stb && (cnt <= CNT_W'(1));
  assign txd       = busy ? sh[0] : 1'b1;

  AST_LOAD_AT_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> (bit_stb && cnt <= CNT_W'(1))); // R11

  AST_BITS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !bit_stb && !abort) |=> ($stable(sh) && $stable(cnt))); // R2

  AST_ABORT_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    abort |=> !busy); // R10

endmodule

// File: rtl/serial_tx_brk.sv
module serial_tx_brk
  import serial_tx_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int OVS    = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              baud_tick16,
  input  logic              tx_en,
  input  logic              send_brk,
  input  logic              brk_long,
  input  logic              fmt9,
  input  logic              par_en,
  input  logic              par_odd,
  input  logic              wr_valid,
  output logic              wr_ready,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              wr_bit8,
  output logic              txd,
  output logic              tx_done
);
  localparam int FRAME_W   = DATA_W + 8;
  localparam int CNT_W     = $clog2(FRAME_W + 1);
  localparam int BRK_SHORT = DATA_W + 2;
  localparam int BRK_LONG  = DATA_W + 5;

  logic               bit_stb;
  logic               slot_free;
  logic               busy;
  logic               load;
  logic               take;
  logic               pre_pend;
  logic               hold_full;
  logic [DATA_W-1:0]  held_data;
  logic               held_bit8;
  frame_kind_e        kind;
  logic [FRAME_W-1:0] vec;
  logic [CNT_W-1:0]   len;

  tx_baud_strobe #(.OVS(OVS)) u_baud (
    .clk     (clk),
    .rst_n   (rst_n),
    .en      (tx_en),
    .tick    (baud_tick16),
    .bit_stb (bit_stb)
  );

  tx_hold_reg #(.DATA_W(DATA_W)) u_hold (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (wr_valid),
    .in_ready  (wr_ready),
    .in_data   (wr_data),
    .in_bit8   (wr_bit8),
    .take      (take),
    .full      (hold_full),
    .held_data (held_data),
    .held_bit8 (held_bit8)
  );

  always_comb begin
    if (pre_pend)      kind = FK_IDLE;
    else if (send_brk) kind = FK_BREAK;
    else               kind = FK_DATA;
  end

  assign load = slot_free && (pre_pend || send_brk || hold_full);
  assign take = load && (kind == FK_DATA);

  always_ff @(posedge clk) begin
    if (!rst_n || !tx_en) begin
      pre_pend <= 1'b1;
    end else if (load && kind == FK_IDLE) begin
      pre_pend <= 1'b0;
    end
  end

  tx_frame_build #(
    .DATA_W    (DATA_W),
    .FRAME_W   (FRAME_W),
    .CNT_W     (CNT_W),
    .BRK_SHORT (BRK_SHORT),
    .BRK_LONG  (BRK_LONG)
  ) u_build (
    .kind     (kind),
    .fmt9     (fmt9),
    .par_en   (par_en),
    .par_odd  (par_odd),
    .brk_long (brk_long),
    .data     (held_data),
    .bit8     (held_bit8),
    .vec      (vec),
    .len      (len)
  );

  tx_shift_out #(.FRAME_W(FRAME_W), .CNT_W(CNT_W)) u_shift (
    .clk       (clk),
    .rst_n     (rst_n),
    .abort     (!tx_en),
    .bit_stb   (bit_stb),
    .load      (load),
    .vec       (vec),
    .len       (len),
    .txd       (txd),
    .busy      (busy),
    .slot_free (slot_free)
  );

  assign tx_done = !hold_full && !busy;

  AST_LINE_IDLE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_en |=> txd); // R10

  AST_PREAMBLE_ARMED: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_en) |-> pre_pend); // R7

  AST_BREAK_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (load && send_brk && !pre_pend) |-> !take); // R5

  AST_DONE_WHEN_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    tx_done |-> (wr_ready && !busy)); // R9

endmodule

// File: tb/tb_serial_tx_brk.sv
module tb_serial_tx_brk;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic baud_tick16 = 1'b0;
  logic tx_en = 1'b0, send_brk = 1'b0, brk_long = 1'b0;
  logic fmt9 = 1'b0, par_en = 1'b0, par_odd = 1'b0;
  logic wr_valid = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic wr_bit8 = 1'b0;
  logic wr_ready, txd, tx_done;

  always #2.5 clk = ~clk;

  serial_tx_brk dut (
    .clk(clk), .rst_n(rst_n), .baud_tick16(baud_tick16), .tx_en(tx_en),
    .send_brk(send_brk), .brk_long(brk_long), .fmt9(fmt9), .par_en(par_en),
    .par_odd(par_odd), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_data(wr_data), .wr_bit8(wr_bit8), .txd(txd), .tx_done(tx_done)
  );

  int checks = 0;
  int failures = 0;
  int cyc = 0;
  int gap = 1;
  int tcnt = 0;
  bit finished = 1'b0;

  task automatic chk(input bit ok, input string tag, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d at cycle %0d", tag, what, act, exp, cyc);
    end
  endtask

  // Tick source: one pulse every 'gap' cycles
  always @(negedge clk) begin
    if (tcnt + 1 >= gap) begin
      tcnt <= 0;
      baud_tick16 <= 1'b1;
    end else begin
      tcnt <= tcnt + 1;
      baud_tick16 <= 1'b0;
    end
  end

  // Reference model
  int    m_sub;
  int    m_q[$];
  bit    m_pre, m_full, m_b8, m_acc, m_full0, m_stb;
  logic [7:0] m_d;
  string m_tag = "R2";

  function automatic bit par_bits(input logic [7:0] d, input int n, input bit odd);
    int ones = 0;
    for (int i = 0; i < n; i++) if (d[i]) ones++;
    return ((ones % 2) == 1) ^ odd;
  endfunction

  always @(posedge clk) begin
    cyc++;
    if (!rst_n) begin
      m_sub = 0; m_q.delete(); m_pre = 1; m_full = 0; m_d = 0; m_b8 = 0;
    end else begin
      m_acc = wr_valid && !m_full;
      m_full0 = m_full;
      if (!tx_en) begin
        m_q.delete(); m_sub = 0; m_pre = 1;
      end else begin
        m_stb = baud_tick16 && (m_sub == 15);
        if (baud_tick16) m_sub = (m_sub + 1) % 16;
        if (m_stb) begin
          if (m_q.size() > 0) void'(m_q.pop_front());
          if (m_q.size() == 0) begin
            if (m_pre) begin
              for (int i = 0; i < 10 + int'(fmt9); i++) m_q.push_back(1);
              m_pre = 0; m_tag = "R7";
            end else if (send_brk) begin
              for (int i = 0; i < (brk_long ? 13 : 10) + int'(fmt9); i++) m_q.push_back(0);
              m_q.push_back(1); m_tag = "R5 R6";
            end else if (m_full0) begin
              m_q.push_back(0);
              if (fmt9) begin
                for (int i = 0; i < 8; i++) m_q.push_back(int'(m_d[i]));
                m_q.push_back(par_en ? int'(par_bits(m_d, 8, par_odd)) : int'(m_b8));
                m_tag = par_en ? "R3 R4" : "R4";
              end else begin
                for (int i = 0; i < 7; i++) m_q.push_back(int'(m_d[i]));
                m_q.push_back(par_en ? int'(par_bits(m_d, 7, par_odd)) : int'(m_d[7]));
                m_tag = par_en ? "R3" : "R2";
              end
              m_q.push_back(1);
              m_full = 0;
            end
          end
        end
      end
      if (m_acc) begin
        m_full = 1; m_d = wr_data; m_b8 = wr_bit8;
      end
    end
  end

  // Per-cycle comparison and falling-edge log
  int  falls[$];
  logic prev_txd = 1'b1;
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      chk(txd === ((m_q.size() > 0) ? 1'(m_q[0]) : 1'b1), m_tag, "txd",
          int'(txd), (m_q.size() > 0) ? m_q[0] : 1);
      chk(wr_ready === !m_full, "R8", "wr_ready", int'(wr_ready), int'(!m_full));
      chk(tx_done === (!m_full && m_q.size() == 0), "R9", "tx_done",
          int'(tx_done), int'(!m_full && m_q.size() == 0));
      if (prev_txd === 1'b1 && txd === 1'b0) falls.push_back(cyc);
      prev_txd = txd;
    end
  end

  task automatic send(input logic [7:0] d, input logic b8);
    @(negedge clk);
    wr_valid = 1'b1; wr_data = d; wr_bit8 = b8;
    while (!wr_ready) @(negedge clk);
    @(negedge clk);
    wr_valid = 1'b0;
  endtask

  task automatic wait_done();
    @(negedge clk);
    while (!tx_done) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  task automatic finish_run();
    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    chk(1'b0, "WATCHDOG", "timeout", 0, 1);
    finish_run();
  end

  initial begin
    repeat (4) @(negedge clk);
    chk(txd === 1'b1, "R1", "reset txd", int'(txd), 1);
    chk(wr_ready === 1'b1, "R1", "reset wr_ready", int'(wr_ready), 1);
    chk(tx_done === 1'b1, "R1", "reset tx_done", int'(tx_done), 1);
    rst_n = 1'b1;

    // R7 preamble then R2 plain bytes
    @(negedge clk); tx_en = 1'b1;
    send(8'hA5, 1'b0); send(8'h3C, 1'b0); wait_done();

    // R3 parity even and odd
    par_en = 1'b1; par_odd = 1'b0;
    send(8'h55, 1'b0); send(8'h13, 1'b0); wait_done();
    par_odd = 1'b1;
    send(8'h55, 1'b0); send(8'hFE, 1'b0); wait_done();

    // R4 nine-bit frames, then with parity
    par_en = 1'b0; fmt9 = 1'b1;
    send(8'hFF, 1'b1); send(8'h81, 1'b0); send(8'h00, 1'b1); wait_done();
    par_en = 1'b1; par_odd = 1'b0;
    send(8'h07, 1'b0); wait_done();
    par_odd = 1'b1;
    send(8'h07, 1'b1); wait_done();

    // R11 back-to-back zero bytes, 8-bit no parity, gap 1
    par_en = 1'b0; fmt9 = 1'b0;
    falls.delete();
    send(8'h00, 1'b0); send(8'h00, 1'b0); wait_done();
    chk(falls.size() == 2, "R11", "start edges", falls.size(), 2);
    if (falls.size() == 2)
      chk(falls[1] - falls[0] == 160, "R11", "start spacing", falls[1] - falls[0], 160);

    // R5 R6 breaks, short then long, with a byte waiting
    @(negedge clk); send_brk = 1'b1; brk_long = 1'b0;
    send(8'h5A, 1'b0);
    repeat (500) @(negedge clk);
    chk(wr_ready === 1'b0, "R5", "byte held during break", int'(wr_ready), 0);
    @(negedge clk); send_brk = 1'b0; wait_done();
    fmt9 = 1'b1; brk_long = 1'b1;
    @(negedge clk); send_brk = 1'b1;
    repeat (600) @(negedge clk);
    send_brk = 1'b0; wait_done();
    fmt9 = 1'b0;
    @(negedge clk); send_brk = 1'b1;
    repeat (300) @(negedge clk);
    send_brk = 1'b0; wait_done();

    // Slower tick
    gap = 3;
    send(8'hC3, 1'b0); send(8'h1E, 1'b0); wait_done();
    gap = 1;

    // R10 disable mid-frame, write while disabled, re-enable
    send(8'hF0, 1'b0);
    repeat (60) @(negedge clk);
    tx_en = 1'b0;
    @(negedge clk);
    chk(txd === 1'b1, "R10", "txd after disable", int'(txd), 1);
    send(8'h96, 1'b0);
    repeat (100) @(negedge clk);
    chk(wr_ready === 1'b0, "R10", "byte kept while disabled", int'(wr_ready), 0);
    chk(txd === 1'b1, "R10", "line high while disabled", int'(txd), 1);
    tx_en = 1'b1;
    wait_done();

    finish_run();
  end
endmodule